// File: doc/BRIEF.md
# Re-encoding BER Monitor

This block estimates the channel bit error rate of a K=7 convolutional link without knowing the transmitted data. The decoded output bits are passed through a local copy of the encoder. Each regenerated symbol set is compared against the hard decisions of the symbol set that was received one decoder latency earlier. Any disagreement is taken to be a channel error on that symbol.

One strobe, `step_vld`, marks each decoder step. It carries the soft symbols just received and the decoded bit released by the decoder for that step. The block registers a flag for each symbol and a combined flag. It feeds the number of flagged symbols through a divide-by-8 prescaler into a saturating accumulator. Measurement periods are whole multiples of 1000 decoded bits. At the end of each period the scaled count is published and a one-cycle interrupt is raised.

Top module: `reenc_ber_mon`

## Requirements
- R1: The hard decision of each received 3-bit soft symbol is its most significant bit, where 0 stands for data 0. Flag `err_g1`/`err_g2`/`err_g3` is 1 when that hard decision differs from the regenerated G1/G2/G3 symbol.
- R2: Regeneration uses generators 171, 133 and 145 (octal) for G1, G2 and G3. The most significant tap weights the newest decoded bit. The encoder history is all zeros after reset.
- R3: The decoded bit of step N is compared with the symbols received at step N-71. Before 71 steps have been received, the delayed symbols read as all zeros.
- R4: `err_any` is the OR of `err_g1` and `err_g2`, plus `err_g3` only when `rate_third` is 1 (rate 1/3). At rate 1/2, `err_g3` is still reported but `err_any` ignores it.
- R5: When `period_k` = P > 0, a measurement period spans exactly 1000*P strobes. `ber_irq` is high for exactly one cycle, the cycle after the strobe that ends the period.
- R6: The published `ber_count` equals the number of symbol errors counted in the period divided by 8 and rounded down. A symbol error is counted for G1 and G2 always, and for G3 only at rate 1/3. `ber_count` changes only together with `ber_irq`.
- R7: When the scaled count exceeds the all-ones value of `ber_count`, the count saturates at all ones (FFFFh at the default width) and does not wrap.
- R8: At the end of a period the prescaler residue, the accumulator and the period counter all clear. The next period's count is independent of the previous one.
- R9: When `period_k` is 0, measurement is stopped: the counters are held clear and `ber_irq` stays low.
- R10: After a synchronous active-low reset, all four flags, `ber_count` and `ber_irq` are 0.
- R11: In cycles without `step_vld`, the flags hold their values and nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_vld | input | 1 | One decoder step: new symbols and a decoded bit are present |
| dec_bit | input | 1 | Decoded bit released by the decoder at this step |
| rx_g1 | input | 3 | Received G1 soft symbol |
| rx_g2 | input | 3 | Received G2 soft symbol |
| rx_g3 | input | 3 | Received G3 soft symbol |
| rate_third | input | 1 | 1 = rate 1/3, 0 = rate 1/2 |
| period_k | input | 24 | Measurement period in units of 1000 decoded bits; 0 stops measurement |
| err_g1 | output | 1 | G1 mismatch on the latest step |
| err_g2 | output | 1 | G2 mismatch on the latest step |
| err_g3 | output | 1 | G3 mismatch on the latest step |
| err_any | output | 1 | Combined mismatch flag |
| ber_count | output | 16 | Scaled error count of the last completed period |
| ber_irq | output | 1 | One-cycle pulse when a new count is published |

## Verification
A wrong stage in the symbol delay line shows at the flags, but only 71 strobes after the corrupted symbol set entered. A fault in the regeneration history shows as bursts of flags on clean data, up to six strobes long. Faults in the prescaler, the accumulator or the period counter stay hidden until a period closes, which is at least 1000 strobes later. They then appear as a wrong published value or a misplaced interrupt. A residue that survives the clear shows only as an off-by-one count in the following period, so the checks compare periods whose totals sit just below a multiple of eight.

// File: rtl/reenc_ber_pkg.sv
// Shared constants and types for the re-encoding BER monitor.
// Assumes a rate-1/n K=7 code with three generators; bit g of a symbol set is generator g.
package reenc_ber_pkg;
    localparam int unsigned CODE_K = 7;
    localparam int unsigned N_GEN  = 3;
    // Tap words packed low-to-high: G1 = 171, G2 = 133, G3 = 145 (octal); MSB taps the newest bit.
    localparam logic [N_GEN*CODE_K-1:0] GEN_TAPS = {7'o145, 7'o133, 7'o171};
    typedef logic [N_GEN-1:0] sym_set_t;
endpackage

// File: rtl/ber_sym_delay.sv
// Hard-decision delay line: holds DEPTH symbol sets and shifts once per decoder step.
// The output is the set that entered DEPTH steps ago. All stages reset to zero (data 0).
module ber_sym_delay #(
    parameter int unsigned DEPTH = 71,
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [DEPTH];

    // Shift the whole line by one stage on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) stage[i] <= '0;
        end else if (adv) begin
            stage[0] <= din;
            for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/ber_reencoder.sv
// Local K=7 encoder fed with decoded bits. The code output is combinational from the
// incoming bit and the stored history; the history advances on each step.
// Assumes the transmit encoder also started from an all-zero state.
module ber_reencoder
    import reenc_ber_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     bit_in,
    output sym_set_t code
);
    logic [CODE_K-2:0] hist_q;
    logic [CODE_K-1:0] window;

    assign window = {bit_in, hist_q};

    for (genvar g = 0; g < int'(N_GEN); g++) begin : g_tap
        assign code[g] = ^(window & GEN_TAPS[g*CODE_K +: CODE_K]);
    end

    // Keep the K-1 most recent decoded bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= window[CODE_K-1:1];
    end
endmodule

// File: rtl/ber_period_ctr.sv
// Measurement period timer: a mod-BLK_LEN step counter advances a block counter.
// period_end marks the step that completes period_k blocks. A zero period holds both clear.
module ber_period_ctr #(
    parameter int unsigned BLK_LEN = 1000,
    parameter int unsigned PER_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [PER_W-1:0] period_k,
    output logic             enabled,
    output logic             period_end
);
    localparam int unsigned SUB_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;

    logic [SUB_W-1:0] sub_q;
    logic [PER_W-1:0] blk_q;
    logic [PER_W:0]   blk_inc;
    logic             sub_last;

    assign enabled    = |period_k;
    assign sub_last   = (sub_q == SUB_W'(BLK_LEN - 1));
    assign blk_inc    = {1'b0, blk_q} + (PER_W+1)'(1);
    assign period_end = adv && enabled && sub_last && (blk_inc >= {1'b0, period_k});

    // Advance the sub-counter and the block counter; restart at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enabled) begin
            sub_q <= '0;
            blk_q <= '0;
        end else if (adv) begin
            if (period_end) begin
                sub_q <= '0;
                blk_q <= '0;
            end else if (sub_last) begin
                sub_q <= '0;
                blk_q <= blk_inc[PER_W-1:0];
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/ber_err_accum.sv
// Error prescaler and saturating accumulator. Every 2**PRE_LOG2 symbol errors add one count.
// At period end the count is published, an interrupt pulses, and the prescaler and accumulator clear.
// Assumes PRE_LOG2 >= NERR_W, so at most one carry leaves the prescaler per step.
module ber_err_accum #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned PRE_LOG2 = 3,
    parameter int unsigned NERR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              enabled,
    input  logic              period_end,
    input  logic [NERR_W-1:0] n_err,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PRE_LOG2-1:0] pre_q;
    logic [CNT_W-1:0]    acc_q;
    logic [PRE_LOG2:0]   pre_sum;
    logic [CNT_W-1:0]    acc_next;

    assign pre_sum  = {1'b0, pre_q} + (PRE_LOG2+1)'(n_err);
    assign acc_next = (acc_q == CNT_MAX) ? CNT_MAX : acc_q + CNT_W'(pre_sum[PRE_LOG2]);

    // Accumulate, publish at period end, clear while measurement is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            acc_q   <= '0;
            count_q <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= period_end;
            if (!enabled) begin
                pre_q <= '0;
                acc_q <= '0;
            end else if (period_end) begin
                count_q <= acc_next;
                pre_q   <= '0;
                acc_q   <= '0;
            end else if (adv) begin
                pre_q <= pre_sum[PRE_LOG2-1:0];
                acc_q <= acc_next;
            end
        end
    end
endmodule

// File: rtl/reenc_ber_mon.sv
// Re-encoding BER monitor top. It regenerates symbols from decoded bits and compares them
// with hard decisions delayed by LATENCY steps. It flags mismatches per symbol and keeps a
// prescaled, saturating error count per measurement period.
// Assumes one step_vld per decoder step, carrying that step's symbols and released bit.
module reenc_ber_mon
    import reenc_ber_pkg::*;
#(
    parameter int unsigned LATENCY  = 71,
    parameter int unsigned SYM_W    = 3,
    parameter int unsigned PER_W    = 24,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned BLK_LEN  = 1000,
    parameter int unsigned PRE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_vld,
    input  logic             dec_bit,
    input  logic [SYM_W-1:0] rx_g1,
    input  logic [SYM_W-1:0] rx_g2,
    input  logic [SYM_W-1:0] rx_g3,
    input  logic             rate_third,
    input  logic [PER_W-1:0] period_k,
    output logic             err_g1,
    output logic             err_g2,
    output logic             err_g3,
    output logic             err_any,
    output logic [CNT_W-1:0] ber_count,
    output logic             ber_irq
);
    localparam int unsigned NERR_W = $clog2(N_GEN + 1);

    sym_set_t          rx_hard;
    sym_set_t          rx_late;
    sym_set_t          recode;
    sym_set_t          miss;
    sym_set_t          counted;
    logic [NERR_W-1:0] n_err;
    logic              meas_on;
    logic              per_end;

    assign rx_hard = {rx_g3[SYM_W-1], rx_g2[SYM_W-1], rx_g1[SYM_W-1]};

    ber_sym_delay #(.DEPTH(LATENCY), .WIDTH(N_GEN)) u_dly (
        .clk (clk),
        .rst_n (rst_n),
        .adv (step_vld),
        .din (rx_hard),
        .dout (rx_late)
    );

    ber_reencoder u_enc (
        .clk (clk),
        .rst_n (rst_n),
        .adv (step_vld),
        .bit_in (dec_bit),
        .code (recode)
    );

    assign miss    = rx_late ^ recode;
    assign counted = miss & {rate_third, {(N_GEN-1){1'b1}}};

    // Count the flagged symbols that take part in this rate.
    always_comb begin
        n_err = '0;
        for (int g = 0; g < int'(N_GEN); g++) n_err = n_err + NERR_W'(counted[g]);
    end

    // Register the per-symbol and combined flags on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_g1  <= 1'b0;
            err_g2  <= 1'b0;
            err_g3  <= 1'b0;
            err_any <= 1'b0;
        end else if (step_vld) begin
            err_g1  <= miss[0];
            err_g2  <= miss[1];
            err_g3  <= miss[2];
            err_any <= |counted;
        end
    end

    ber_period_ctr #(.BLK_LEN(BLK_LEN), .PER_W(PER_W)) u_per (
        .clk (clk),
        .rst_n (rst_n),
        .adv (step_vld),
        .period_k (period_k),
        .enabled (meas_on),
        .period_end (per_end)
    );

    ber_err_accum #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2), .NERR_W(NERR_W)) u_acc (
        .clk (clk),
        .rst_n (rst_n),
        .adv (step_vld),
        .enabled (meas_on),
        .period_end (per_end),
        .n_err (n_err),
        .count_q (ber_count),
        .irq (ber_irq)
    );
endmodule

// File: rtl/reenc_ber_chk.sv
// Port-level checker for reenc_ber_mon, attached by bind below.
module reenc_ber_chk #(
    parameter int unsigned PER_W = 24,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_vld,
    input logic             rate_third,
    input logic [PER_W-1:0] period_k,
    input logic             err_g1,
    input logic             err_g2,
    input logic             err_g3,
    input logic             err_any,
    input logic [CNT_W-1:0] ber_count,
    input logic             ber_irq
);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!ber_irq && ber_count == '0 && !err_g1 && !err_g2 && !err_g3 && !err_any));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ber_irq |=> !ber_irq);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !step_vld) |=> $stable({err_g1, err_g2, err_g3, err_any}));

    // R4
    any_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld |=> (err_any == (err_g1 || err_g2 || (err_g3 && $past(rate_third)))));

    // R6
    count_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ber_count != $past(ber_count)) |-> ber_irq);

    // R9
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(period_k) == '0) |-> !ber_irq);
endmodule

bind reenc_ber_mon reenc_ber_chk #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .step_vld (step_vld),
    .rate_third (rate_third),
    .period_k (period_k),
    .err_g1 (err_g1),
    .err_g2 (err_g2),
    .err_g3 (err_g3),
    .err_any (err_any),
    .ber_count (ber_count),
    .ber_irq (ber_irq)
);

// File: tb/sim_reenc_ber_mon.sv
module sim_reenc_ber_mon;
    localparam int BCNT_W = 8;
    localparam int MAXC   = (1 << BCNT_W) - 1;
    localparam int LAT    = 71;
    localparam int HLEN   = 4096;

    // Table entry: {rate_third, corrupt mask g3g2g1, expected {any,g3,g2,g1}}
    localparam logic [7:0] VEC [12] = '{
        8'b1_000_0000, 8'b1_001_1001, 8'b1_010_1010, 8'b1_100_1100,
        8'b0_100_0100, 8'b0_011_1011, 8'b1_111_1111, 8'b0_111_1111,
        8'b0_001_1001, 8'b1_110_1110, 8'b0_000_0000, 8'b0_101_1101
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_vld = 1'b0;
    logic        dec_bit = 1'b0;
    logic [2:0]  rx_g1 = '0;
    logic [2:0]  rx_g2 = '0;
    logic [2:0]  rx_g3 = '0;
    logic        rate_third = 1'b1;
    logic [23:0] period_k = '0;
    logic        err_g1, err_g2, err_g3, err_any, ber_irq;
    logic [BCNT_W-1:0] ber_count;

    int tests = 0;
    int fails = 0;
    int n = 0;
    int errs = 0;
    int bits = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [5:0]  tx_st = '0;
    logic        data_h [HLEN];
    logic [2:0]  mask_h [HLEN];

    always #5 clk = ~clk;

    reenc_ber_mon #(.CNT_W(BCNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .dec_bit(dec_bit),
        .rx_g1(rx_g1), .rx_g2(rx_g2), .rx_g3(rx_g3), .rate_third(rate_third),
        .period_k(period_k), .err_g1(err_g1), .err_g2(err_g2), .err_g3(err_g3),
        .err_any(err_any), .ber_count(ber_count), .ber_irq(ber_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] enc3(input logic [6:0] w);
        enc3[0] = ^(w & 7'o171);
        enc3[1] = ^(w & 7'o133);
        enc3[2] = ^(w & 7'o145);
    endfunction

    function automatic logic [2:0] pat(input int k);
        if (k % 5 == 0)      return 3'b111;
        else if (k % 7 == 3) return 3'b010;
        else if (k % 11 == 4) return 3'b100;
        else                 return 3'b000;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        step_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0; errs = 0; bits = 0; tx_st = '0;
        @(negedge clk);
        chk("R10 flags after reset", {err_any, err_g3, err_g2, err_g1}, 4'b0000);
        chk("R10 count after reset", ber_count, 0);
        chk("R10 irq after reset", ber_irq, 0);
    endtask

    // One decoder step: transmit-encode a fresh bit, corrupt per mask, release bit n-71.
    task automatic step(input logic [2:0] mask);
        logic d;
        logic [6:0] w;
        logic [2:0] tx;
        logic [2:0] em;
        int ne;
        logic ei;
        d = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        w = {d, tx_st};
        tx = enc3(w) ^ mask;
        tx_st = w[6:1];
        data_h[n] = d;
        mask_h[n] = mask;
        rx_g1 = {tx[0], lfsr[2:1]};
        rx_g2 = {tx[1], lfsr[4:3]};
        rx_g3 = {tx[2], lfsr[6:5]};
        dec_bit = (n >= LAT) ? data_h[n-LAT] : 1'b0;
        step_vld = 1'b1;
        @(negedge clk);
        step_vld = 1'b0;
        em = (n >= LAT) ? mask_h[n-LAT] : 3'b000;
        chk("R1 R2 R3 per-symbol flags", {err_g3, err_g2, err_g1}, em);
        chk("R4 combined flag", err_any, em[0] | em[1] | (em[2] & rate_third));
        ei = 1'b0;
        if (period_k != 0) begin
            ne = int'(em[0]) + int'(em[1]) + int'(em[2] & rate_third);
            errs += ne;
            bits++;
            if (bits == 1000 * int'(period_k)) begin
                ei = 1'b1;
                chk("R6 R7 published count", ber_count, ((errs >> 3) > MAXC) ? MAXC : (errs >> 3));
                errs = 0;
                bits = 0;
            end
        end
        chk("R5 R9 interrupt timing", ber_irq, ei);
        n++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired, run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R10 irq held in reset", ber_irq, 0);
        do_reset();

        // Table walk, measurement stopped (R9): each corruption is checked 71 steps later.
        period_k = 24'd0;
        for (int i = 0; i < 12; i++) begin
            rate_third = VEC[i][7];
            step(VEC[i][6:4]);
            for (int j = 0; j < 70; j++) step(3'b000);
            step(3'b000);
            repeat (3) @(negedge clk);
            // R11 flags hold through idle cycles
            chk("R1 R4 R11 table flags after idle", {err_any, err_g3, err_g2, err_g1}, VEC[i][3:0]);
            chk("R9 R11 no interrupt while idle", ber_irq, 0);
        end

        // Two back-to-back periods of one block with a mixed error pattern (R5 R6 R8).
        do_reset();
        period_k = 24'd1;
        rate_third = 1'b1;
        for (int k = 0; k < 2000; k++) step(pat(k));

        // Two-block period: no interrupt after 1000 steps (R5).
        do_reset();
        period_k = 24'd2;
        for (int k = 0; k < 2000; k++) begin
            step(pat(k + 3));
            if (k == 999) chk("R5 no interrupt mid-period", ber_irq, 0);
        end

        // Saturation: every symbol wrong.
        do_reset();
        period_k = 24'd1;
        rate_third = 1'b1;
        for (int k = 0; k < 1000; k++) step(3'b111);
        chk("R7 count saturates at all ones", ber_count, MAXC);

        // Rate 1/2: G3 errors are not counted.
        do_reset();
        rate_third = 1'b0;
        for (int k = 0; k < 1000; k++) step(3'b100);
        chk("R6 rate-half G3 excluded", ber_count, 0);

        // Prescaler residue clears at the period boundary (R8).
        do_reset();
        rate_third = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            if (k < 2)          step(3'b111);
            else if (k == 2)    step(3'b001);
            else if (k == 1000) step(3'b001);
            else                step(3'b000);
            if (k == 999)  chk("R8 seven errors give zero", ber_count, 0);
            if (k == 1999) chk("R8 residue cleared between periods", ber_count, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule